// File: doc/BRIEF.md
# I2C Controller Interrupt Vector Unit

This block collects the event flags of an I2C master controller, holds them in a status register and gates them with an interrupt-enable register. It then offers one small vector code for the most urgent pending enabled event. The bus engine that produces the events is outside the block. It reaches the block as single-cycle event pulses, one per event kind, together with two live bus conditions (bus busy and receive-shift full) and two strobes that mark accesses to the data registers.

Software uses a simple register port. A service routine reads the vector register over and over. Each read returns the most urgent event and acknowledges it, so the routine acts on each code until it reads 0. Flags can also be cleared by writing ones to the status register. The receive-ready and transmit-ready flags stay up after a vector read and clear only when the matching data register is accessed. One interrupt output is high while any enabled flag is pending.

Event index i (0..6), mask bit i and status bit i all belong to one event. The order is: 0 arbitration lost, 1 no-acknowledge, 2 access ready, 3 receive ready, 4 transmit ready, 5 stop detected, 6 addressed as slave. Event i reports vector code i+1.

Top module: `i2c_irq_vector`

## Requirements
- R1: After reset all flags and the mask are 0, irqOut is 0, and reads of mask, status and vector all return 0 while busBusy and rxShiftFull are low.
- R2: A pulse on evtPulse[i] sets status bit i whether or not it is enabled. Reading status (offset 0x08) returns the flags in bits 6:0, rxShiftFull in bit 11, busBusy in bit 12 and 0 in all other bits.
- R3: The mask register at offset 0x04 is written from regWrData[6:0] and read back in bits 6:0, with the upper bits reading 0.
- R4: Writing the status register clears each flag whose write-data bit (6:0) is 1 and leaves flags whose bit is 0 unchanged. Bits 11 and 12 cannot be written.
- R5: Reading the vector register (offset 0x28) returns i+1 for the lowest index i whose flag and mask bit are both 1, or 0 if there is none. Code 1 (arbitration lost) has the highest priority and code 7 (addressed as slave) the lowest.
- R6: A vector read that returns 1, 2, 3, 6 or 7 clears the flag it reported. A read that returns 4 (receive ready) or 5 (transmit ready) leaves that flag set.
- R7: A pulse on rxDataRd clears the receive-ready flag (bit 3). A pulse on txDataWr clears the transmit-ready flag (bit 4).
- R8: irqOut is 1 exactly while at least one flag is set whose mask bit is also set.
- R9: An event pulse in the same cycle as any clear of the same flag (status write, vector acknowledge or data access) leaves the flag set.
- R10: Read data appears on regRdData in the cycle after regRdEn and reflects the state before that edge. Reads at other offsets return 0. Writes to the vector register or to other offsets change no state.
- R11: Repeated vector reads step through all pending enabled events in priority order. Once the data-access strobes have cleared receive ready and transmit ready, the reads end at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | ADDR_W | Register byte offset |
| regWrData | input | DATA_W | Register write data |
| regRdData | output | DATA_W | Register read data, one cycle after regRdEn |
| evtPulse | input | 7 | Event pulses from the bus engine, index as above |
| rxDataRd | input | 1 | Receive data register was read |
| txDataWr | input | 1 | Transmit data register was written |
| busBusy | input | 1 | Live bus-busy condition |
| rxShiftFull | input | 1 | Live receive-shift-full condition |
| irqOut | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that an event pulse always leaves its flag set, even against a clear in the same cycle. They also check that a vector read acknowledges the flags it should and that the receive-ready flag drops after a data read. Further cycle checks cover the timing of live bits in status reads and the rule that irqOut can only rise after an event or a mask write. The full priority order and the draining sequence are shown only by the bench's scenarios, which compare every read against a reference model. The same holds for the exemption of receive ready and transmit ready from acknowledgement and for reads at unused offsets.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

  localparam int EVT_COUNT = 7;
  localparam int VEC_W     = $clog2(EVT_COUNT + 1);

  // event indices; code reported on the vector is index + 1
  localparam int EV_ARB_LOST = 0;
  localparam int EV_NO_ACK   = 1;
  localparam int EV_ACC_RDY  = 2;
  localparam int EV_RX_RDY   = 3;
  localparam int EV_TX_RDY   = 4;
  localparam int EV_STOP     = 5;
  localparam int EV_ADDR_SLV = 6;

  // flags that a vector read does not acknowledge
  localparam logic [EVT_COUNT-1:0] ACK_KEEP =
    (EVT_COUNT'(1) << EV_RX_RDY) | (EVT_COUNT'(1) << EV_TX_RDY);

  localparam int OFS_MASK   = 'h04;
  localparam int OFS_STATUS = 'h08;
  localparam int OFS_VECTOR = 'h28;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_MASK,
    SEL_STATUS,
    SEL_VECTOR
  } rdSel_e;

  typedef struct packed {
    logic   wrMask;
    logic   wrStatus;
    logic   rdVector;
    logic   rdAny;
    rdSel_e rdSel;
  } ctlStrobes_t;

endpackage

// File: rtl/irqv_prio.sv
module irqv_prio
  import irqv_pkg::*;
#(
  parameter int N_EVT = EVT_COUNT,
  localparam int CODE_W = $clog2(N_EVT + 1)
) (
  input  logic [N_EVT-1:0]  pending,
  output logic [CODE_W-1:0] code
);

  // lowest set index wins; scan from the top so the lowest overrides
  always_comb begin
    code = '0;
    for (int i = N_EVT - 1; i >= 0; i--) begin
      if (pending[i]) code = CODE_W'(i + 1);
    end
  end

endmodule

// File: rtl/irqv_control.sv
module irqv_control
  import irqv_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  output ctlStrobes_t       ctl
);

  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_VECTOR = ADDR_W'(OFS_VECTOR);

  always_comb begin
    ctl          = '0;
    ctl.wrMask   = regWrEn && (regAddr == A_MASK);
    ctl.wrStatus = regWrEn && (regAddr == A_STATUS);
    ctl.rdAny    = regRdEn;
    ctl.rdVector = regRdEn && (regAddr == A_VECTOR);
    if (regRdEn) begin
      unique case (regAddr)
        A_MASK:   ctl.rdSel = SEL_MASK;
        A_STATUS: ctl.rdSel = SEL_STATUS;
        A_VECTOR: ctl.rdSel = SEL_VECTOR;
        default:  ctl.rdSel = SEL_NONE;
      endcase
    end
  end

endmodule

// File: rtl/irqv_datapath.sv
module irqv_datapath
  import irqv_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int RSFULL_BIT = 11,
  parameter int BUSY_BIT   = 12,
  localparam int N_EVT     = EVT_COUNT,
  localparam int CODE_W    = VEC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobes_t       ctl,
  input  logic [DATA_W-1:0] wrData,
  input  logic [N_EVT-1:0]  evtPulse,
  input  logic              rxDataRd,
  input  logic              txDataWr,
  input  logic              busBusy,
  input  logic              rxShiftFull,
  input  logic [CODE_W-1:0] vecCode,
  output logic [N_EVT-1:0]  flagQ,
  output logic [N_EVT-1:0]  maskQ,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut
);

  logic [N_EVT-1:0] ackClr;
  logic [N_EVT-1:0] w1cClr;
  logic [N_EVT-1:0] accClr;
  logic [N_EVT-1:0] flagNext;
  logic [DATA_W-1:0] statusWord;
  logic [DATA_W-1:0] rdMux;
  logic unusedWrBits;

  assign unusedWrBits = ^wrData[DATA_W-1:N_EVT];

  // acknowledge of the reported event on a vector read
  for (genvar i = 0; i < N_EVT; i++) begin : g_ack
    assign ackClr[i] = ctl.rdVector && (vecCode == CODE_W'(i + 1)) && !ACK_KEEP[i];
    if (i == EV_RX_RDY) begin : g_rx
      assign accClr[i] = rxDataRd;
    end else if (i == EV_TX_RDY) begin : g_tx
      assign accClr[i] = txDataWr;
    end else begin : g_none
      assign accClr[i] = 1'b0;
    end
  end

  assign w1cClr   = ctl.wrStatus ? wrData[N_EVT-1:0] : '0;
  // a new event outranks any clear in the same cycle
  assign flagNext = (flagQ & ~(ackClr | w1cClr | accClr)) | evtPulse;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flagQ <= '0;
      maskQ <= '0;
    end else begin
      flagQ <= flagNext;
      if (ctl.wrMask) maskQ <= wrData[N_EVT-1:0];
    end
  end

  always_comb begin
    statusWord                = '0;
    statusWord[N_EVT-1:0]     = flagQ;
    statusWord[RSFULL_BIT]    = rxShiftFull;
    statusWord[BUSY_BIT]      = busBusy;
  end

  always_comb begin
    unique case (ctl.rdSel)
      SEL_MASK:   rdMux = DATA_W'(maskQ);
      SEL_STATUS: rdMux = statusWord;
      SEL_VECTOR: rdMux = DATA_W'(vecCode);
      default:    rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdData <= '0;
    else if (ctl.rdAny) rdData <= rdMux;
  end

  assign irqOut = |(flagQ & maskQ);

endmodule

// File: rtl/i2c_irq_vector.sv
module i2c_irq_vector
  import irqv_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 16,
  parameter int RSFULL_BIT = 11,
  parameter int BUSY_BIT   = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 regWrEn,
  input  logic                 regRdEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [DATA_W-1:0]    regWrData,
  output logic [DATA_W-1:0]    regRdData,
  input  logic [EVT_COUNT-1:0] evtPulse,
  input  logic                 rxDataRd,
  input  logic                 txDataWr,
  input  logic                 busBusy,
  input  logic                 rxShiftFull,
  output logic                 irqOut
);

  ctlStrobes_t          ctl;
  logic [EVT_COUNT-1:0] flagQ;
  logic [EVT_COUNT-1:0] maskQ;
  logic [VEC_W-1:0]     vecCode;

  irqv_control #(.ADDR_W(ADDR_W)) u_ctl (
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .regAddr (regAddr),
    .ctl     (ctl)
  );

  irqv_prio #(.N_EVT(EVT_COUNT)) u_prio (
    .pending (flagQ & maskQ),
    .code    (vecCode)
  );

  irqv_datapath #(
    .DATA_W     (DATA_W),
    .RSFULL_BIT (RSFULL_BIT),
    .BUSY_BIT   (BUSY_BIT)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl         (ctl),
    .wrData      (regWrData),
    .evtPulse    (evtPulse),
    .rxDataRd    (rxDataRd),
    .txDataWr    (txDataWr),
    .busBusy     (busBusy),
    .rxShiftFull (rxShiftFull),
    .vecCode     (vecCode),
    .flagQ       (flagQ),
    .maskQ       (maskQ),
    .rdData      (regRdData),
    .irqOut      (irqOut)
  );

endmodule

// File: rtl/i2c_irq_vector_chk.sv
module i2c_irq_vector_chk
  import irqv_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 regWrEn,
  input logic                 regRdEn,
  input logic [ADDR_W-1:0]    regAddr,
  input logic [DATA_W-1:0]    regWrData,
  input logic [DATA_W-1:0]    regRdData,
  input logic [EVT_COUNT-1:0] evtPulse,
  input logic                 rxDataRd,
  input logic                 busBusy,
  input logic                 irqOut,
  input logic [EVT_COUNT-1:0] flagQ,
  input logic [EVT_COUNT-1:0] maskQ
);

  logic                 vecReadQ;
  logic [EVT_COUNT-1:0] evtQ;
  logic [2:0]           ackIdx;
  logic                 ackCode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vecReadQ <= 1'b0;
      evtQ     <= '0;
    end else begin
      vecReadQ <= regRdEn && (regAddr == ADDR_W'(OFS_VECTOR));
      evtQ     <= evtPulse;
    end
  end

  assign ackIdx  = regRdData[2:0] - 3'd1;
  assign ackCode = (regRdData == DATA_W'(1)) || (regRdData == DATA_W'(2)) ||
                   (regRdData == DATA_W'(3)) || (regRdData == DATA_W'(6)) ||
                   (regRdData == DATA_W'(7));

  a_r9_event_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (|evtPulse) |=> ((flagQ & $past(evtPulse)) == $past(evtPulse)));

  a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (vecReadQ && ackCode) |-> (!flagQ[ackIdx] || evtQ[ackIdx]));

  a_r7_rx_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rxDataRd && !evtPulse[EV_RX_RDY]) |=> !flagQ[EV_RX_RDY]);

  a_r10_status_live_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (regRdEn && regAddr == ADDR_W'(OFS_STATUS)) |=> (regRdData[12] == $past(busBusy)));

  a_r8_irq_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irqOut) |-> ($past(|evtPulse) ||
                       $past(regWrEn && regAddr == ADDR_W'(OFS_MASK))));

  a_r4_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (regWrEn && regAddr == ADDR_W'(OFS_STATUS) && regWrData[EV_ACC_RDY] &&
     !evtPulse[EV_ACC_RDY]) |=> !flagQ[EV_ACC_RDY]);

  a_r5_masked_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (regRdEn && regAddr == ADDR_W'(OFS_VECTOR) && maskQ == '0) |=> (regRdData == '0));

endmodule

bind i2c_irq_vector i2c_irq_vector_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .regWrEn   (regWrEn),
  .regRdEn   (regRdEn),
  .regAddr   (regAddr),
  .regWrData (regWrData),
  .regRdData (regRdData),
  .evtPulse  (evtPulse),
  .rxDataRd  (rxDataRd),
  .busBusy   (busBusy),
  .irqOut    (irqOut),
  .flagQ     (flagQ),
  .maskQ     (maskQ)
);

// File: tb/i2c_irq_vector_test.sv
`timescale 1ns/1ps
module i2c_irq_vector_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic [6:0]  evtPulse = '0;
  logic        rxDataRd = 1'b0;
  logic        txDataWr = 1'b0;
  logic        busBusy = 1'b0;
  logic        rxShiftFull = 1'b0;
  logic        irqOut;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [6:0] mFlags = '0;
  logic [6:0] mMask = '0;

  always #2 clk = ~clk;

  i2c_irq_vector uut (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .evtPulse(evtPulse), .rxDataRd(rxDataRd), .txDataWr(txDataWr),
    .busBusy(busBusy), .rxShiftFull(rxShiftFull), .irqOut(irqOut)
  );

  function automatic int expVector(logic [6:0] f, logic [6:0] m);
    for (int i = 0; i < 7; i++) if (f[i] && m[i]) return i + 1;
    return 0;
  endfunction

  function automatic logic [15:0] expRead(logic [7:0] a, logic bb, logic rsf);
    case (a)
      8'h04:   return {9'b0, mMask};
      8'h08:   return {3'b0, bb, rsf, 4'b0, mFlags};
      8'h28:   return 16'(expVector(mFlags, mMask));
      default: return 16'h0;
    endcase
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, update model at the edge, check at next negedge
  task automatic step(logic we, logic re, logic [7:0] a, logic [15:0] wd,
                      logic [6:0] ev, logic rxr, logic txw, logic bb, logic rsf,
                      string tag);
    logic [15:0] er;
    logic [6:0]  clr;
    int          code;
    string       t;
    regWrEn = we; regRdEn = re; regAddr = a; regWrData = wd;
    evtPulse = ev; rxDataRd = rxr; txDataWr = txw; busBusy = bb; rxShiftFull = rsf;
    er   = expRead(a, bb, rsf);
    code = expVector(mFlags, mMask);
    clr  = '0;
    if (re && a == 8'h28 && code != 0 && code != 4 && code != 5) clr[code-1] = 1'b1;
    if (we && a == 8'h08) clr |= wd[6:0];
    if (rxr) clr[3] = 1'b1;
    if (txw) clr[4] = 1'b1;
    @(posedge clk);
    mFlags = (mFlags & ~clr) | ev;
    if (we && a == 8'h04) mMask = wd[6:0];
    @(negedge clk);
    if (tag != "") t = tag;
    else if (a == 8'h28) t = "R5/R6";
    else if (a == 8'h08) t = "R2/R4";
    else if (a == 8'h04) t = "R3";
    else t = "R10";
    if (re) check(t, regRdData, er);
    check("R8", 16'(irqOut), 16'(|(mFlags & mMask)));
    regWrEn = 0; regRdEn = 0; evtPulse = '0; rxDataRd = 0; txDataWr = 0;
  endtask

  task automatic rd(logic [7:0] a, string tag);
    step(0, 1, a, 16'h0, 7'h0, 0, 0, 0, 0, tag);
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d, string tag);
    step(1, 0, a, d, 7'h0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", 16'(irqOut), 16'h0);
    rd(8'h04, "R1"); rd(8'h08, "R1"); rd(8'h28, "R1");

    // R2 status with live bits; R3 mask upper bits
    step(0, 0, 8'h00, 0, 7'h24, 0, 0, 0, 0, "R2");
    step(0, 1, 8'h08, 0, 7'h00, 0, 0, 1, 1, "R2");
    wr(8'h04, 16'hFFFF, "R3"); rd(8'h04, "R3");
    // R10 writes to vector / unused offset ignored, unused read returns 0
    wr(8'h28, 16'h0000, "R10"); wr(8'h10, 16'h007F, "R10");
    rd(8'h04, "R10"); rd(8'h08, "R10"); rd(8'h3C, "R10");
    // R4 write-one-to-clear, zeros keep
    wr(8'h08, 16'h1804, "R4"); rd(8'h08, "R4");
    wr(8'h08, 16'h0000, "R4"); rd(8'h08, "R4");
    // R9 event beats clear in same cycle
    step(1, 0, 8'h08, 16'h007F, 7'h20, 0, 0, 0, 0, "R9");
    rd(8'h08, "R9");
    step(0, 0, 8'h00, 0, 7'h08, 1, 0, 0, 0, "R9");
    rd(8'h08, "R9");
    wr(8'h08, 16'h007F, "R4");

    // R11 drain with R5 priority, R6 exemptions, R7 data access clears
    step(0, 0, 8'h00, 0, 7'h7F, 0, 0, 0, 0, "R11");
    rd(8'h28, "R11"); rd(8'h28, "R11"); rd(8'h28, "R11");
    rd(8'h28, "R6");  rd(8'h28, "R6");
    step(0, 0, 8'h00, 0, 7'h00, 1, 0, 0, 0, "R7");
    rd(8'h08, "R7");
    rd(8'h28, "R11"); rd(8'h28, "R6");
    step(0, 0, 8'h00, 0, 7'h00, 0, 1, 0, 0, "R7");
    rd(8'h08, "R7");
    rd(8'h28, "R11"); rd(8'h28, "R11"); rd(8'h28, "R11");
    // R5 masked events are skipped
    step(0, 0, 8'h00, 0, 7'h41, 0, 0, 0, 0, "R5");
    wr(8'h04, 16'h0040, "R5"); rd(8'h28, "R5");
    wr(8'h04, 16'h0000, "R8"); rd(8'h28, "R5");
    wr(8'h08, 16'h007F, "R4");

    // constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [7:0]  a;
      logic [6:0]  ev;
      int          sel;
      sel = $urandom_range(0, 9);
      a = (sel < 4) ? 8'h28 : (sel < 7) ? 8'h08 : (sel < 9) ? 8'h04 : 8'($urandom);
      ev = '0;
      for (int k = 0; k < 7; k++) if ($urandom_range(0, 15) == 0) ev[k] = 1'b1;
      step($urandom_range(0, 3) == 0, $urandom_range(0, 1) == 1, a,
           16'($urandom), ev, $urandom_range(0, 7) == 0, $urandom_range(0, 7) == 0,
           1'($urandom), 1'($urandom), "");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule